// File: doc/BRIEF.md
# Byte-Parity Checker with Error Capture

This block sits beside a 32-bit-wide SRAM and gives every byte of it an even parity bit. On the write side it produces four parity bits from the write data, and the surrounding logic stores them next to the word. On the read side it takes the word and its four stored parity bits, recomputes parity over all four bytes and flags every byte whose stored bit disagrees. Checking runs only while the `parity_en` input is high.

A detected failure sets a sticky detect flag. The flag drives either a maskable interrupt or a non-maskable interrupt. Once the NMI enable is set, the maskable interrupt stays silent. When capture is enabled, the first failure also records the word-aligned offset, the set of failing bytes and the ID of the bus master that read. That record stays frozen until software clears the flag. The check always covers the whole stored word, so an unaligned access can report bytes outside the requested data.

Software reaches the block through a small register port with a 3-bit select: 0 = capture control (bit 0 enables capture), 1 = interrupt enables (bit 0 maskable, bit 1 NMI), 2 = status (bit 0 detect flag), 3 = clear (write 1 to bit 0), 4 = capture record.

Top module: `sram_byte_parity_guard`

## Requirements
- R1: `wr_par[k]` is the XOR of the bits of byte k of `wr_data` (even parity), combinationally, for k = 0..3.
- R2: A read with `rd_valid` and `parity_en` high, where any byte's recomputed parity differs from `rd_par`, sets the detect flag (select 2, bit 0) at the next clock edge. The flag then stays set until it is cleared.
- R3: While `parity_en` is low, no read sets the detect flag, whatever its data and parity.
- R4: Writing select 3 with bit 0 = 1 clears the flag at the next edge, and writing it with bit 0 = 0 has no effect. If a new error arrives in the same cycle as a clear, the flag stays set.
- R5: Reading select 3 returns the current detect flag in bit 0.
- R6: The capture record (select 4) holds the word-aligned offset in bits [15:0] with bits [1:0] zero, the failing-byte mask in bits [19:16] (bit 16+k set when byte k failed), and the master ID in bits [26:24] (010 CPU, 011 debugger, 110 DMA). It is loaded on an error when capture is enabled (select 0, bit 0) and the flag is clear or is being cleared in that cycle.
- R7: While the flag is set and not being cleared, later errors leave the capture record unchanged.
- R8: While capture is disabled, errors still set the flag but leave the capture record unchanged.
- R9: The NMI enable (select 1, bit 1) can be set by a register write but not cleared by one; only reset clears it. The maskable enable (select 1, bit 0) is freely writable.
- R10: `irq` equals flag AND maskable enable AND NOT NMI enable. `nmi` equals flag AND NMI enable.
- R11: All four bytes of the stored word are checked on every read, whatever the byte offset in `rd_addr`. An unaligned read therefore reports failing bytes of the word even when they lie outside the requested data.
- R12: After reset every register reads zero, `irq` and `nmi` are low, and selects 5 to 7 always read zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| parity_en | input | 1 | Enables parity checking on reads |
| wr_data | input | 32 | Data being written to the SRAM |
| wr_par | output | 4 | Parity bits to store with `wr_data` |
| rd_valid | input | 1 | A read word is presented this cycle |
| rd_addr | input | 16 | Byte offset of the read access |
| rd_data | input | 32 | Word read from the SRAM |
| rd_par | input | 4 | Parity bits read with the word |
| rd_master | input | 3 | Bus master ID of the read |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 3 | Register select |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_sel` |
| irq | output | 1 | Maskable parity interrupt |
| nmi | output | 1 | Non-maskable parity interrupt |

## Verification
A wrong detect flag shows one cycle after the offending read: on `irq` or `nmi` and on the status and clear selects. A capture record that was wrongly reloaded or wrongly held becomes visible as soon as select 4 is read after the next error, so the bench reads it after every error it injects. A lost or cleared NMI enable shows at once as `irq` rising in place of `nmi`. The bench compares every output against its reference model on every cycle, so any of these faults is caught within one clock of its cause.

// File: rtl/sram_byte_parity_guard.sv
module sram_byte_parity_guard #(
  parameter int ADDR_W = 16,
  parameter int LANES  = 4,
  parameter int ID_W   = 3
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 parity_en,
  input  logic [LANES*8-1:0]   wr_data,
  output logic [LANES-1:0]     wr_par,
  input  logic                 rd_valid,
  input  logic [ADDR_W-1:0]    rd_addr,
  input  logic [LANES*8-1:0]   rd_data,
  input  logic [LANES-1:0]     rd_par,
  input  logic [ID_W-1:0]      rd_master,
  input  logic                 reg_we,
  input  logic [2:0]           reg_sel,
  input  logic [31:0]          reg_wdata,
  output logic [31:0]          reg_rdata,
  output logic                 irq,
  output logic                 nmi
);
  localparam int LSB = $clog2(LANES);
  localparam int OFF_W = ADDR_W - LSB;
  localparam logic [2:0] SEL_CTRL = 3'd0;
  localparam logic [2:0] SEL_IEN  = 3'd1;
  localparam logic [2:0] SEL_STAT = 3'd2;
  localparam logic [2:0] SEL_CLR  = 3'd3;
  localparam logic [2:0] SEL_CAP  = 3'd4;

  logic [LANES-1:0] rd_bad;

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    assign wr_par[k] = ^wr_data[8*k +: 8];
    assign rd_bad[k] = (^rd_data[8*k +: 8]) ^ rd_par[k];
  end

  logic             flag_q, cap_en_q, irq_en_q, nmi_en_q;
  logic [OFF_W-1:0] cap_off_q;
  logic [LANES-1:0] cap_mask_q;
  logic [ID_W-1:0]  cap_id_q;

  wire err_hit  = rd_valid & parity_en & (|rd_bad);
  wire clr_hit  = reg_we & (reg_sel == SEL_CLR) & reg_wdata[0];
  wire cap_load = err_hit & cap_en_q & (~flag_q | clr_hit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q   <= 1'b0;
      cap_en_q <= 1'b0;
      irq_en_q <= 1'b0;
      nmi_en_q <= 1'b0;
    end else begin
      if (err_hit)      flag_q <= 1'b1;
      else if (clr_hit) flag_q <= 1'b0;
      if (reg_we && reg_sel == SEL_CTRL) cap_en_q <= reg_wdata[0];
      if (reg_we && reg_sel == SEL_IEN) begin
        irq_en_q <= reg_wdata[0];
        nmi_en_q <= nmi_en_q | reg_wdata[1];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cap_off_q  <= '0;
      cap_mask_q <= '0;
      cap_id_q   <= '0;
    end else if (cap_load) begin
      cap_off_q  <= rd_addr[ADDR_W-1:LSB];
      cap_mask_q <= rd_bad;
      cap_id_q   <= rd_master;
    end
  end

  always_comb begin
    reg_rdata = '0;
    unique case (reg_sel)
      SEL_CTRL: reg_rdata[0] = cap_en_q;
      SEL_IEN: begin
        reg_rdata[0] = irq_en_q;
        reg_rdata[1] = nmi_en_q;
      end
      SEL_STAT, SEL_CLR: reg_rdata[0] = flag_q;
      SEL_CAP: begin
        reg_rdata[ADDR_W-1:LSB]  = cap_off_q;
        reg_rdata[16 +: LANES]   = cap_mask_q;
        reg_rdata[24 +: ID_W]    = cap_id_q;
      end
      default: reg_rdata = '0;
    endcase
  end

  assign irq = flag_q & irq_en_q & ~nmi_en_q;
  assign nmi = flag_q & nmi_en_q;
endmodule

module sram_byte_parity_guard_chk #(
  parameter int LANES = 4,
  parameter int OFF_W = 14,
  parameter int ID_W  = 3
) (
  input logic               clk,
  input logic               rst_n,
  input logic               parity_en,
  input logic               rd_valid,
  input logic [LANES*8-1:0] rd_data,
  input logic [LANES-1:0]   rd_par,
  input logic               reg_we,
  input logic [2:0]         reg_sel,
  input logic [31:0]        reg_wdata,
  input logic               flag_q,
  input logic               cap_en_q,
  input logic               nmi_en_q,
  input logic [OFF_W-1:0]   cap_off_q,
  input logic [LANES-1:0]   cap_mask_q,
  input logic [ID_W-1:0]    cap_id_q,
  input logic               irq,
  input logic               nmi
);
  function automatic logic word_bad(input logic [LANES*8-1:0] d, input logic [LANES-1:0] p);
    logic bad;
    bad = 1'b0;
    for (int k = 0; k < LANES; k++) begin
      if (($countones(d[8*k +: 8]) % 2) != int'(p[k])) bad = 1'b1;
    end
    return bad;
  endfunction

  wire clr_wr = reg_we && reg_sel == 3'd3 && reg_wdata[0];
  wire seen   = rd_valid && parity_en && word_bad(rd_data, rd_par);

  assert_err_sets_flag_R2: assert property (@(posedge clk) disable iff (!rst_n)
    seen |=> flag_q);
  assert_flag_sticky_R2: assert property (@(posedge clk) disable iff (!rst_n)
    flag_q && !clr_wr |=> flag_q);
  assert_gate_off_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !flag_q && !(rd_valid && parity_en) |=> !flag_q);
  assert_capture_frozen_R7: assert property (@(posedge clk) disable iff (!rst_n)
    flag_q && !clr_wr |=> $stable(cap_off_q) && $stable(cap_mask_q) && $stable(cap_id_q));
  assert_capture_off_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !cap_en_q |=> $stable(cap_off_q) && $stable(cap_mask_q) && $stable(cap_id_q));
  assert_nmi_en_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    nmi_en_q |=> nmi_en_q);
  assert_irq_nmi_exclusive_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !(irq && nmi));
endmodule

bind sram_byte_parity_guard sram_byte_parity_guard_chk #(
  .LANES(LANES), .OFF_W(OFF_W), .ID_W(ID_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .parity_en(parity_en), .rd_valid(rd_valid),
  .rd_data(rd_data), .rd_par(rd_par), .reg_we(reg_we), .reg_sel(reg_sel),
  .reg_wdata(reg_wdata), .flag_q(flag_q), .cap_en_q(cap_en_q), .nmi_en_q(nmi_en_q),
  .cap_off_q(cap_off_q), .cap_mask_q(cap_mask_q), .cap_id_q(cap_id_q),
  .irq(irq), .nmi(nmi)
);

// File: tb/sram_byte_parity_guard_test.sv
`timescale 1ns/1ps
module sram_byte_parity_guard_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        parity_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic [3:0]  wr_par;
  logic        rd_valid = 1'b0;
  logic [15:0] rd_addr = '0;
  logic [31:0] rd_data = '0;
  logic [3:0]  rd_par = '0;
  logic [2:0]  rd_master = '0;
  logic        reg_we = 1'b0;
  logic [2:0]  reg_sel = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        irq, nmi;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  sram_byte_parity_guard uut (
    .clk(clk), .rst_n(rst_n), .parity_en(parity_en), .wr_data(wr_data), .wr_par(wr_par),
    .rd_valid(rd_valid), .rd_addr(rd_addr), .rd_data(rd_data), .rd_par(rd_par),
    .rd_master(rd_master), .reg_we(reg_we), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .irq(irq), .nmi(nmi)
  );

  function automatic logic [3:0] even_par(input logic [31:0] d);
    logic [3:0] p;
    for (int k = 0; k < 4; k++) begin
      int ones;
      ones = 0;
      for (int b = 0; b < 8; b++) if (d[8*k + b]) ones++;
      p[k] = (ones % 2) == 1;
    end
    return p;
  endfunction

  // reference model state
  bit      m_flag, m_cap_en, m_irq_en, m_nmi_en;
  int      m_off, m_mask, m_id;

  function automatic logic [31:0] exp_rdata(input logic [2:0] s);
    logic [31:0] v;
    v = '0;
    case (s)
      3'd0: v[0] = m_cap_en;
      3'd1: begin v[0] = m_irq_en; v[1] = m_nmi_en; end
      3'd2, 3'd3: v[0] = m_flag;
      3'd4: v = 32'(m_off) | (32'(m_mask) << 16) | (32'(m_id) << 24);
      default: v = '0;
    endcase
    return v;
  endfunction

  function automatic string sel_tag(input logic [2:0] s);
    case (s)
      3'd0: return "R8";
      3'd1: return "R9";
      3'd2: return "R2";
      3'd3: return "R5";
      3'd4: return "R6";
      default: return "R12";
    endcase
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      m_flag = 0; m_cap_en = 0; m_irq_en = 0; m_nmi_en = 0;
      m_off = 0; m_mask = 0; m_id = 0;
    end else begin
      int  bad;
      bit  err, clr;
      bad = int'(even_par(rd_data) ^ rd_par);
      err = rd_valid && parity_en && bad != 0;
      clr = reg_we && reg_sel == 3'd3 && reg_wdata[0];
      if (err && m_cap_en && (!m_flag || clr)) begin
        m_off  = (int'(rd_addr) / 4) * 4;
        m_mask = bad;
        m_id   = int'(rd_master);
      end
      if (err) m_flag = 1;
      else if (clr) m_flag = 0;
      if (reg_we && reg_sel == 3'd0) m_cap_en = reg_wdata[0];
      if (reg_we && reg_sel == 3'd1) begin
        m_irq_en = reg_wdata[0];
        if (reg_wdata[1]) m_nmi_en = 1;
      end
    end
    #1;
    check("R1", 32'(wr_par), 32'(even_par(wr_data)));
    check("R10", 32'(irq), 32'(m_flag && m_irq_en && !m_nmi_en));
    check("R10", 32'(nmi), 32'(m_flag && m_nmi_en));
    check(sel_tag(reg_sel), reg_rdata, exp_rdata(reg_sel));
  end

  task automatic wreg(input logic [2:0] s, input logic [31:0] v);
    reg_we = 1'b1; reg_sel = s; reg_wdata = v;
    @(negedge clk);
    reg_we = 1'b0; reg_wdata = '0;
  endtask

  task automatic rd(input logic [15:0] a, input logic [31:0] d, input logic [3:0] flip,
                    input logic [2:0] id);
    rd_valid = 1'b1; rd_addr = a; rd_data = d; rd_par = even_par(d) ^ flip; rd_master = id;
    @(negedge clk);
    rd_valid = 1'b0;
  endtask

  task automatic peek(input logic [2:0] s, output logic [31:0] v);
    reg_sel = s;
    #0.5;
    v = reg_rdata;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R12 reset state
    peek(3'd2, v); check("R12 status after reset", v, 32'h0);
    peek(3'd4, v); check("R12 capture after reset", v, 32'h0);
    peek(3'd6, v); check("R12 unused select", v, 32'h0);
    check("R12 irq after reset", 32'(irq), 0);
    // R1 write parity patterns
    wr_data = 32'h0103_07FF; #0.5; check("R1 mixed bytes", 32'(wr_par), 32'hA);
    wr_data = 32'hFFFF_FFFF; #0.5; check("R1 all ones", 32'(wr_par), 32'h0);
    wr_data = 32'h8000_0001; #0.5; check("R1 single bits", 32'(wr_par), 32'h9);
    // R3 gating off
    rd(16'h0010, 32'hDEAD_BEEF, 4'hF, 3'b010);
    peek(3'd2, v); check("R3 no flag with parity_en low", v, 32'h0);
    // enable capture and maskable interrupt
    parity_en = 1'b1;
    wreg(3'd0, 32'h1);
    wreg(3'd1, 32'h1);
    rd(16'h0100, 32'h1234_5678, 4'h0, 3'b010);
    peek(3'd2, v); check("R2 good read leaves flag clear", v, 32'h0);
    rd(16'h1235, 32'hCAFE_F00D, 4'b0101, 3'b010);
    peek(3'd2, v); check("R2 flag after error", v, 32'h1);
    peek(3'd3, v); check("R5 clear select reads flag", v, 32'h1);
    check("R10 irq with flag", 32'(irq), 1);
    peek(3'd4, v); check("R6 first capture", v, 32'h0205_1234);
    // R7 later error does not overwrite
    rd(16'h0040, 32'h0, 4'b1000, 3'b110);
    peek(3'd4, v); check("R7 capture frozen", v, 32'h0205_1234);
    // R4 clear with bit0=0 no effect, then real clear
    wreg(3'd3, 32'h0);
    peek(3'd2, v); check("R4 zero write no effect", v, 32'h1);
    wreg(3'd3, 32'h1);
    peek(3'd2, v); check("R4 flag cleared", v, 32'h0);
    check("R4 irq dropped", 32'(irq), 0);
    // R8 capture disabled
    wreg(3'd0, 32'h0);
    rd(16'h0200, 32'h5555_AAAA, 4'b0010, 3'b011);
    peek(3'd2, v); check("R8 flag still set", v, 32'h1);
    peek(3'd4, v); check("R8 capture unchanged", v, 32'h0205_1234);
    // R4/R6 clear and error in the same cycle
    wreg(3'd0, 32'h1);
    reg_we = 1'b1; reg_sel = 3'd3; reg_wdata = 32'h1;
    rd(16'h0302, 32'h0F0F_0F0F, 4'b1100, 3'b011);
    reg_we = 1'b0; reg_wdata = '0;
    peek(3'd2, v); check("R4 error wins over clear", v, 32'h1);
    peek(3'd4, v); check("R6 capture on clear-and-error", v, 32'h030C_0300);
    // R10/R9 NMI enable
    wreg(3'd1, 32'h3);
    check("R10 irq suppressed", 32'(irq), 0);
    check("R10 nmi asserted", 32'(nmi), 1);
    wreg(3'd1, 32'h0);
    peek(3'd1, v); check("R9 nmi enable not cleared by write", v, 32'h2);
    check("R9 nmi still asserted", 32'(nmi), 1);
    // R11 unaligned read flags a byte of the whole word
    wreg(3'd3, 32'h1);
    rd(16'h0003, 32'h1122_3344, 4'b0001, 3'b110);
    peek(3'd4, v); check("R11 unaligned capture", v, 32'h0601_0000);
    // R12/R9 reset clears NMI enable
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    peek(3'd1, v); check("R9 reset clears enables", v, 32'h0);
    peek(3'd2, v); check("R12 flag clear after reset", v, 32'h0);
    repeat (2) @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule